// File: doc/BRIEF.md
# Write-Once Fuse Array Controller

This block holds a one-time-programmable fuse array in flip-flops and exposes it through a small write-only command port. Software writes a word pointer, a bit pointer and a tracking-mode flag, then issues a program command. A program sets exactly one bit of the selected fuse word. The word under the pointer, and its lock word, are always visible on the read outputs.

A lock map holds one flag per fuse bit. A program is tracked when the mode flag is 0 and the word pointer lies outside the low block of control words. A tracked program of a bit whose lock flag is clear sets both the fuse bit and the lock flag. A tracked program of a bit that is already locked is refused, and the block raises a sticky error that records the word and bit of the refused attempt. Untracked programs always go through and never touch the lock map.

After reset every fuse word is zero except a configured serial word, which holds the serial value, and the word after it, which holds the bitwise complement. The lock map starts empty.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: While reset is low and right after it, every fuse word reads 0 except word SERIAL_WORD, which reads SERIAL_VAL, and word SERIAL_WORD+1, which reads ~SERIAL_VAL. Every lock word reads 0, err_flag is 0, and err_word and err_bit are 0.
- R2: A write with cfg_sel=0 loads the word pointer from cfg_wdata[ADDR_W-1:0]. cfg_sel=1 loads the bit pointer from cfg_wdata[BIT_W-1:0]. cfg_sel=2 loads the mode flag from cfg_wdata[0]. From the next cycle on, rd_data and rd_lock show the fuse and lock words at the pointer. Writes with cfg_sel of 5, 6 or 7 change nothing.
- R3: A program is issued only by a write with cfg_sel=3 and cfg_wdata[0]=1. The same write with cfg_wdata[0]=0 changes nothing.
- R4: A program that is carried out ORs the single pointed bit into the fuse word. No other bit changes, and no fuse bit is ever cleared.
- R5: A tracked program (mode 0, word pointer >= CTRL_WORDS) of an unlocked bit sets that fuse bit and its lock flag in the cycle after the command. A locked bit is always also set in the fuse word.
- R6: A tracked program of a bit that is already locked leaves the fuse and lock words unchanged. It sets err_flag and loads err_word and err_bit with the word and bit pointers of that attempt.
- R7: With the mode flag at 1, a program is carried out without touching the lock map and never raises an error, even when repeated.
- R8: A program at a word pointer below CTRL_WORDS is carried out without touching the lock map and never raises an error.
- R9: err_flag stays set until a write with cfg_sel=4 and cfg_wdata[0]=1 clears it. A cfg_sel=4 write with cfg_wdata[0]=0 leaves it set. A later refused attempt sets err_flag again and reloads err_word and err_bit.
- R10: A bit set by an untracked program stays unlocked. One later tracked program of that bit is accepted and locks it, and the next tracked program of it is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Command write strobe |
| cfg_sel | input | 3 | Command select: 0 word pointer, 1 bit pointer, 2 mode, 3 program, 4 error clear |
| cfg_wdata | input | FUSE_W | Command data |
| rd_data | output | FUSE_W | Fuse word at the word pointer |
| rd_lock | output | FUSE_W | Lock word at the word pointer |
| err_flag | output | 1 | Sticky refused-program flag |
| err_word | output | ADDR_W | Word pointer of the last refused program |
| err_bit | output | BIT_W | Bit pointer of the last refused program |

## Verification
The bench builds the block with 32 words, 4 control words and the serial pair at words 20 and 21. With only 32 words, a full read-back sweep after reset is short and confirms the exact serial and complement placement. With the control region at 4, a few-valued pseudo-random pointer stream falls often on both tracked and untracked words, and it also falls on already-locked bits, so refusals, repeats and the untracked-then-tracked sequence occur many times. A behavioural reference model runs beside the design and is compared every cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

   // Command select codes seen on cfg_sel
   typedef enum logic [2:0] {
      SEL_WPTR   = 3'd0,
      SEL_BPTR   = 3'd1,
      SEL_MODE   = 3'd2,
      SEL_PROG   = 3'd3,
      SEL_ERRCLR = 3'd4
   } otp_sel_e;

   // Outcome of a command cycle as decided by the guard
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_RAW   = 2'd1,   // program, no lock bookkeeping
      ACT_TRACK = 2'd2,   // program and set lock flag
      ACT_BLOCK = 2'd3    // refused, raise error
   } otp_act_e;

endpackage

// File: rtl/otp_regs.sv
module otp_regs #(
   parameter int ADDR_W = 6,
   parameter int FUSE_W = 32,
   parameter int BIT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [FUSE_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [BIT_W-1:0]  cur_bit,
   output logic              raw_mode,
   output logic              prog_req,
   output logic              err_clr
);
   import otp_pkg::*;

   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cur_bit  <= '0;
         raw_mode <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_WPTR: cur_addr <= cfg_wdata[ADDR_W-1:0];
            SEL_BPTR: cur_bit  <= cfg_wdata[BIT_W-1:0];
            SEL_MODE: raw_mode <= cfg_wdata[0];
            default:  ;
         endcase
      end
   end

   // Strobes that live for the command cycle only
   always_comb begin
      prog_req = cfg_we && (cfg_sel == SEL_PROG)   && cfg_wdata[0];
      err_clr  = cfg_we && (cfg_sel == SEL_ERRCLR) && cfg_wdata[0];
   end

endmodule

// File: rtl/otp_guard.sv
module otp_guard #(
   parameter int ADDR_W     = 6,
   parameter int FUSE_W     = 32,
   parameter int BIT_W      = 5,
   parameter int CTRL_WORDS = 15
) (
   input  logic              prog_req,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [BIT_W-1:0]  cur_bit,
   input  logic              raw_mode,
   input  logic [FUSE_W-1:0] lock_word,
   output otp_pkg::otp_act_e act,
   output logic [FUSE_W-1:0] bit_mask
);
   import otp_pkg::*;

   localparam logic [ADDR_W-1:0] CTRL_LIMIT = ADDR_W'(CTRL_WORDS);

   logic in_track_zone;
   logic already_locked;

   always_comb begin
      bit_mask       = FUSE_W'(1) << cur_bit;
      in_track_zone  = (cur_addr >= CTRL_LIMIT);
      already_locked = |(lock_word & bit_mask);

      if (!prog_req)
         act = ACT_NONE;
      else if (raw_mode || !in_track_zone)
         act = ACT_RAW;
      else if (already_locked)
         act = ACT_BLOCK;
      else
         act = ACT_TRACK;
   end

endmodule

// File: rtl/otp_array.sv
module otp_array #(
   parameter int                  WORDS       = 64,
   parameter int                  FUSE_W      = 32,
   parameter int                  ADDR_W      = 6,
   parameter int                  SERIAL_WORD = 62,
   parameter logic [FUSE_W-1:0]   SERIAL_VAL  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  otp_pkg::otp_act_e act,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [FUSE_W-1:0] bit_mask,
   output logic [FUSE_W-1:0] rd_word,
   output logic [FUSE_W-1:0] rd_lock
);
   import otp_pkg::*;

   logic [FUSE_W-1:0] fuse_q [WORDS];
   logic [FUSE_W-1:0] lock_q [WORDS];
   logic [FUSE_W-1:0] init_w [WORDS];

   logic do_fuse;
   logic do_lock;

   always_comb begin
      do_fuse = (act == ACT_RAW) || (act == ACT_TRACK);
      do_lock = (act == ACT_TRACK);
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      // Reset content: serial word, its complement, or blank
      if (w == SERIAL_WORD) begin : g_ser
         assign init_w[w] = SERIAL_VAL;
      end else if (w == SERIAL_WORD + 1) begin : g_ser_n
         assign init_w[w] = ~SERIAL_VAL;
      end else begin : g_blank
         assign init_w[w] = '0;
      end

      logic hit;
      assign hit = (cur_addr == ADDR_W'(w));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fuse_q[w] <= init_w[w];
            lock_q[w] <= '0;
         end else if (hit) begin
            if (do_fuse) fuse_q[w] <= fuse_q[w] | bit_mask;
            if (do_lock) lock_q[w] <= lock_q[w] | bit_mask;
         end
      end
   end

   always_comb begin
      rd_word = fuse_q[cur_addr];
      rd_lock = lock_q[cur_addr];
   end

endmodule

// File: rtl/otp_errlog.sv
module otp_errlog #(
   parameter int ADDR_W = 6,
   parameter int BIT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  otp_pkg::otp_act_e act,
   input  logic              err_clr,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [BIT_W-1:0]  cur_bit,
   output logic              err_flag,
   output logic [ADDR_W-1:0] err_word,
   output logic [BIT_W-1:0]  err_bit
);
   import otp_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_flag <= 1'b0;
         err_word <= '0;
         err_bit  <= '0;
      end else if (act == ACT_BLOCK) begin
         err_flag <= 1'b1;
         err_word <= cur_addr;
         err_bit  <= cur_bit;
      end else if (err_clr) begin
         err_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
   parameter int                WORDS       = 64,
   parameter int                FUSE_W      = 32,
   parameter int                CTRL_WORDS  = 15,
   parameter int                SERIAL_WORD = 62,
   parameter logic [FUSE_W-1:0] SERIAL_VAL  = FUSE_W'(32'h1357_9BDF),
   localparam int               ADDR_W      = $clog2(WORDS),
   localparam int               BIT_W       = $clog2(FUSE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [FUSE_W-1:0] cfg_wdata,
   output logic [FUSE_W-1:0] rd_data,
   output logic [FUSE_W-1:0] rd_lock,
   output logic              err_flag,
   output logic [ADDR_W-1:0] err_word,
   output logic [BIT_W-1:0]  err_bit
);
   import otp_pkg::*;

   // Elaboration-time parameter checks
   if (WORDS < 4 || (1 << ADDR_W) != WORDS) begin : g_chk_words
      $error("WORDS must be a power of two of at least 4");
   end
   if (FUSE_W < 8 || (1 << BIT_W) != FUSE_W) begin : g_chk_width
      $error("FUSE_W must be a power of two of at least 8");
   end
   if (CTRL_WORDS < 0 || CTRL_WORDS >= WORDS) begin : g_chk_ctrl
      $error("CTRL_WORDS must lie inside the array");
   end
   if (SERIAL_WORD < 0 || SERIAL_WORD + 1 >= WORDS) begin : g_chk_serial
      $error("serial pair must fit inside the array");
   end
   if (ADDR_W > FUSE_W) begin : g_chk_ptr
      $error("word pointer wider than command data");
   end

   logic [ADDR_W-1:0] cur_addr;
   logic [BIT_W-1:0]  cur_bit;
   logic              raw_mode;
   logic              prog_req;
   logic              err_clr;
   otp_act_e          act;
   logic [FUSE_W-1:0] bit_mask;

   otp_regs #(.ADDR_W(ADDR_W), .FUSE_W(FUSE_W), .BIT_W(BIT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cur_addr  (cur_addr),
      .cur_bit   (cur_bit),
      .raw_mode  (raw_mode),
      .prog_req  (prog_req),
      .err_clr   (err_clr)
   );

   otp_guard #(
      .ADDR_W(ADDR_W), .FUSE_W(FUSE_W), .BIT_W(BIT_W), .CTRL_WORDS(CTRL_WORDS)
   ) u_guard (
      .prog_req  (prog_req),
      .cur_addr  (cur_addr),
      .cur_bit   (cur_bit),
      .raw_mode  (raw_mode),
      .lock_word (rd_lock),
      .act       (act),
      .bit_mask  (bit_mask)
   );

   otp_array #(
      .WORDS(WORDS), .FUSE_W(FUSE_W), .ADDR_W(ADDR_W),
      .SERIAL_WORD(SERIAL_WORD), .SERIAL_VAL(SERIAL_VAL)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .cur_addr (cur_addr),
      .bit_mask (bit_mask),
      .rd_word  (rd_data),
      .rd_lock  (rd_lock)
   );

   otp_errlog #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .err_clr  (err_clr),
      .cur_addr (cur_addr),
      .cur_bit  (cur_bit),
      .err_flag (err_flag),
      .err_word (err_word),
      .err_bit  (err_bit)
   );

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
   parameter int ADDR_W     = 6,
   parameter int FUSE_W     = 32,
   parameter int BIT_W      = 5,
   parameter int CTRL_WORDS = 15
) (
   input logic              clk,
   input logic              rst_n,
   input otp_pkg::otp_act_e act,
   input logic              err_clr,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [BIT_W-1:0]  cur_bit,
   input logic [FUSE_W-1:0] rd_data,
   input logic [FUSE_W-1:0] rd_lock,
   input logic              err_flag,
   input logic [ADDR_W-1:0] err_word,
   input logic [BIT_W-1:0]  err_bit
);
   import otp_pkg::*;

   AST_BLOCK_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_BLOCK) |=> (err_flag && err_word == $past(cur_addr) && err_bit == $past(cur_bit))); // R6

   AST_BLOCK_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_BLOCK) |-> rd_lock[cur_bit]); // R6

   AST_TRACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_TRACK) |=> (rd_lock[$past(cur_bit)] && rd_data[$past(cur_bit)])); // R5

   AST_LOCK_IN_FUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_lock & ~rd_data) == '0)); // R5

   AST_LOCK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cur_addr) |-> (($past(rd_lock) & ~rd_lock) == '0)); // R5

   AST_FUSE_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cur_addr) |-> (($past(rd_data) & ~rd_data) == '0)); // R4

   AST_RAW_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_RAW && !err_flag) |=> !err_flag); // R7

   AST_CTRL_UNTRACKED: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_TRACK || act == ACT_BLOCK) |-> (cur_addr >= ADDR_W'(CTRL_WORDS))); // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag); // R9

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(
   .ADDR_W(ADDR_W), .FUSE_W(FUSE_W), .BIT_W(BIT_W), .CTRL_WORDS(CTRL_WORDS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .act      (act),
   .err_clr  (err_clr),
   .cur_addr (cur_addr),
   .cur_bit  (cur_bit),
   .rd_data  (rd_data),
   .rd_lock  (rd_lock),
   .err_flag (err_flag),
   .err_word (err_word),
   .err_bit  (err_bit)
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;

   localparam int          WORDS  = 32;
   localparam int          CTRLW  = 4;
   localparam int          SERW   = 20;
   localparam logic [31:0] SERV   = 32'h5A0F_C3E1;
   localparam int          AW     = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [31:0] rd_data, rd_lock;
   logic        err_flag;
   logic [AW-1:0] err_word;
   logic [4:0]  err_bit;

   always #10 clk = ~clk;   // 50 MHz

   otp_fuse_ctrl #(
      .WORDS(WORDS), .FUSE_W(32), .CTRL_WORDS(CTRLW),
      .SERIAL_WORD(SERW), .SERIAL_VAL(SERV)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rd_data(rd_data), .rd_lock(rd_lock),
      .err_flag(err_flag), .err_word(err_word), .err_bit(err_bit)
   );

   int    checks = 0;
   int    errors = 0;
   bit    cmp_on = 1'b0;
   bit    done   = 1'b0;
   string cur_req = "R1";

   // Behavioural reference model
   logic [31:0] m_fuse [WORDS];
   logic [31:0] m_lock [WORDS];
   int          m_addr, m_bit, m_ew, m_eb;
   bit          m_mode, m_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) begin
            m_fuse[i] = 32'd0;
            m_lock[i] = 32'd0;
         end
         m_fuse[SERW]     = SERV;
         m_fuse[SERW + 1] = ~SERV;
         m_addr = 0; m_bit = 0; m_mode = 0; m_err = 0; m_ew = 0; m_eb = 0;
      end else if (cfg_we) begin
         case (cfg_sel)
            3'd0: m_addr = int'(cfg_wdata % WORDS);
            3'd1: m_bit  = int'(cfg_wdata % 32);
            3'd2: m_mode = cfg_wdata[0];
            3'd3: if (cfg_wdata[0]) begin
               if (!m_mode && m_addr >= CTRLW && m_lock[m_addr][m_bit]) begin
                  m_err = 1; m_ew = m_addr; m_eb = m_bit;
               end else begin
                  m_fuse[m_addr][m_bit] = 1'b1;
                  if (!m_mode && m_addr >= CTRLW) m_lock[m_addr][m_bit] = 1'b1;
               end
            end
            3'd4: if (cfg_wdata[0]) m_err = 0;
            default: ;
         endcase
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   // Compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk("rd_data",  rd_data, m_fuse[m_addr]);
         chk("rd_lock",  rd_lock, m_lock[m_addr]);
         chk("err_flag", {31'd0, err_flag}, {31'd0, m_err});
         chk("err_word", {27'd0, err_word}, 32'(m_ew));
         chk("err_bit",  {27'd0, err_bit},  32'(m_eb));
      end
   end

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic prog_at(input int a, input int b);
      wr(3'd0, 32'(a));
      wr(3'd1, 32'(b));
      wr(3'd3, 32'd1);
   endtask

   // Directed expectation on a port, named by requirement
   task automatic expect_now(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
      string keep;
      keep = cur_req; cur_req = req;
      chk(what, act, exp);
      cur_req = keep;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] rnd;
      repeat (2) @(posedge clk);
      cmp_on = 1'b1;          // R1: outputs compared while in reset
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R1: sweep all words after reset
      cur_req = "R1";
      for (int a = 0; a < WORDS; a++) wr(3'd0, 32'(a));
      wr(3'd0, 32'(SERW));
      idle(1);
      expect_now("R1", "serial word", rd_data, SERV);
      wr(3'd0, 32'(SERW + 1));
      idle(1);
      expect_now("R1", "serial complement", rd_data, ~SERV);

      // R2: pointer loads and ignored selects
      cur_req = "R2";
      wr(3'd0, 32'hFFFF_FFE9);   // low bits give word 9
      wr(3'd1, 32'hFFFF_FFE7);   // low bits give bit 7
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      wr(3'd3, 32'd1);
      idle(1);
      expect_now("R2", "word9 after prog", rd_data, 32'h0000_0080);

      // R3: program strobe with bit0 clear does nothing
      cur_req = "R3";
      wr(3'd1, 32'd2);
      wr(3'd3, 32'hFFFF_FFFE);
      idle(1);
      expect_now("R3", "no program", rd_data, 32'h0000_0080);

      // R4/R5: tracked programs on word 10
      cur_req = "R4";
      prog_at(10, 3);
      prog_at(10, 31);
      prog_at(10, 0);
      idle(1);
      expect_now("R4", "word10 or", rd_data, 32'h8000_0009);
      expect_now("R5", "word10 lock", rd_lock, 32'h8000_0009);

      // R6: repeat is refused
      cur_req = "R6";
      prog_at(10, 3);
      idle(1);
      expect_now("R6", "err_flag", {31'd0, err_flag}, 32'd1);
      expect_now("R6", "err_word", {27'd0, err_word}, 32'd10);
      expect_now("R6", "err_bit",  {27'd0, err_bit}, 32'd3);

      // R9: clear semantics and re-raise
      cur_req = "R9";
      wr(3'd4, 32'd0);
      idle(1);
      expect_now("R9", "clear with 0", {31'd0, err_flag}, 32'd1);
      wr(3'd4, 32'd1);
      idle(1);
      expect_now("R9", "clear with 1", {31'd0, err_flag}, 32'd0);
      prog_at(10, 31);
      idle(1);
      expect_now("R9", "re-raise bit", {27'd0, err_bit}, 32'd31);
      wr(3'd4, 32'd1);

      // R7: mode 1 bypasses tracking
      cur_req = "R7";
      wr(3'd2, 32'd1);
      prog_at(12, 5);
      prog_at(12, 5);
      idle(1);
      expect_now("R7", "no err", {31'd0, err_flag}, 32'd0);
      expect_now("R7", "no lock", rd_lock, 32'd0);

      // R10: later tracked program locks once, then refused
      cur_req = "R10";
      wr(3'd2, 32'd0);
      wr(3'd3, 32'd1);
      idle(1);
      expect_now("R10", "lock set", rd_lock, 32'h0000_0020);
      expect_now("R10", "no err yet", {31'd0, err_flag}, 32'd0);
      wr(3'd3, 32'd1);
      idle(1);
      expect_now("R10", "refused", {31'd0, err_flag}, 32'd1);
      wr(3'd4, 32'd1);

      // R8: control region untracked
      cur_req = "R8";
      prog_at(2, 7);
      prog_at(2, 7);
      idle(1);
      expect_now("R8", "ctrl no err", {31'd0, err_flag}, 32'd0);
      expect_now("R8", "ctrl no lock", rd_lock, 32'd0);
      expect_now("R8", "ctrl fuse", rd_data, 32'h0000_0080);

      // R5/R6 on serial word: already-set bit locks first time
      cur_req = "R5";
      prog_at(SERW, 0);
      prog_at(SERW, 0);
      idle(1);
      expect_now("R6", "serial refused", {31'd0, err_flag}, 32'd1);
      expect_now("R5", "serial fuse", rd_data, SERV);
      wr(3'd4, 32'd1);

      // R4: pseudo-random stream on a few words and bits
      cur_req = "R4";
      rnd = 32'hC0FF_EE11;
      for (int i = 0; i < 600; i++) begin
         rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
         case (rnd[31:29])
            3'd0, 3'd1: wr(3'd0, {29'd0, rnd[2:0]} + 32'd2);
            3'd2:       wr(3'd1, {29'd0, rnd[6:4]});
            3'd3:       wr(3'd2, {31'd0, rnd[8] & rnd[9]});
            3'd4, 3'd5: wr(3'd3, {31'd0, rnd[10] | rnd[11]});
            3'd6:       wr(3'd4, {31'd0, rnd[12] & rnd[13]});
            default:    wr(3'd6, rnd);
         endcase
      end
      idle(3);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule